// File: doc/BRIEF.md
# If-Then Conditional Execution Tracker

This block follows a short conditional block in an instruction pipeline. When an if-then instruction issues, the pipeline loads the tracker with a 4-bit base condition code, the block length (one to four covered instructions) and a then/else letter for each slot after the first. While the block is open, the tracker compares the condition, or its inverse on else slots, with the live N, Z, C and V flags. It raises an execute enable for the instruction at the head of the block, and squashes the instruction when the enable is low.

The pipeline pulses an advance strobe each time a covered instruction retires. The tracker then moves to the next slot and counts down. The block closes after the last slot. Outside a block every instruction commits. Fetch and decode are outside this block.

The controller has two states. In `ST_IDLE` no block is open. In `ST_ACTIVE` a block is being tracked. The transitions are `T_OPEN` (ST_IDLE to ST_ACTIVE on a valid load), `T_RESTART` (ST_ACTIVE to ST_ACTIVE on a valid load), `T_STEP` (ST_ACTIVE to ST_ACTIVE on an advance while more than one slot remains) and `T_CLOSE` (ST_ACTIVE to ST_IDLE on an advance of the last slot).

Top module: `cond_block_tracker`

## Requirements
- R1: After reset `in_block_o` is 0, `remain_o` is 0 and `exec_o` is 1.
- R2: A load with `len_i` from 1 to 4 gives `in_block_o`=1 and `remain_o`=`len_i` in the next cycle.
- R3: The first slot of a block is always a then slot. `exec_o` equals the truth of the base condition on the current flags.
- R4: For slot k (k=2..4), bit k-2 of `else_i` picks the polarity. With the bit at 0, `exec_o` is the truth of the condition. With the bit at 1, `exec_o` is its inverse.
- R5: Flags are packed as `flags_i`={N,Z,C,V}. The condition codes are EQ=0000 (Z), NE=0001 (!Z), CS=0010 (C), CC=0011 (!C), MI=0100 (N), PL=0101 (!N), VS=0110 (V), VC=0111 (!V), HI=1000 (C&!Z), LS=1001 (!C|Z), GE=1010 (N==V), LT=1011 (N!=V), GT=1100 (!Z&N==V), LE=1101 (Z|N!=V). AL=1110 and 1111 are always true.
- R6: While a block is open, each advance strobe without a load lowers `remain_o` by one. The advance that takes it from 1 closes the block, so `in_block_o`=0 and `remain_o`=0 in the next cycle.
- R7: `exec_o` follows the flags in the same cycle. A flag change in the middle of a block changes the outcome for the current slot.
- R8: A valid load while a block is open restarts tracking with the new condition, length and letters.
- R9: A load with `len_i` of 0 or above 4 is ignored. The state, `remain_o` and `in_block_o` keep their values.
- R10: An advance strobe outside a block has no effect. Outside a block `exec_o` is 1.
- R11: When a valid load and an advance arrive in the same cycle, the load wins. `remain_o` becomes the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | If-then instruction issues |
| cond_i | input | 4 | Base condition code |
| len_i | input | 3 | Number of covered instructions |
| else_i | input | 3 | Else letters for slots 2..4 (bit 0 is slot 2) |
| adv_i | input | 1 | Covered instruction advances |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| in_block_o | output | 1 | A block is open |
| exec_o | output | 1 | Commit the current instruction (0 squashes it) |
| remain_o | output | 3 | Slots left in the block, head slot included |

## Verification
A vector table loads one-slot blocks across the signed, unsigned and equality codes. It uses flag sets chosen so that each code's true and false outcomes are both seen, which separates N==V from N!=V and Z-gated codes from plain ones. A four-slot then-then-else-else block shows the polarity shift slot by slot. A flag flip in the middle of that block shows that the enable is live rather than latched. Directed sequences then cover a restart during a block, a load and an advance in the same cycle, lengths that are out of range, and advances while idle. Each of these yields a remaining count that differs from what a wrong priority would give.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } cbt_state_e;

    // condition groups selected by the upper three code bits
    localparam logic [2:0] GRP_ZERO  = 3'd0;
    localparam logic [2:0] GRP_CARRY = 3'd1;
    localparam logic [2:0] GRP_NEG   = 3'd2;
    localparam logic [2:0] GRP_OVF   = 3'd3;
    localparam logic [2:0] GRP_HIGH  = 3'd4;
    localparam logic [2:0] GRP_SGE   = 3'd5;
    localparam logic [2:0] GRP_SGT   = 3'd6;
    localparam logic [2:0] GRP_ALW   = 3'd7;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;
endpackage

// File: rtl/cbt_cond_eval.sv
module cbt_cond_eval
    import cbt_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [CW-1:0] cond_i,
    input  logic [3:0]    flags_i,
    output logic          holds_o
);
    logic n, z, c, v;
    logic base;

    assign n = flags_i[FLAG_N];
    assign z = flags_i[FLAG_Z];
    assign c = flags_i[FLAG_C];
    assign v = flags_i[FLAG_V];

    always_comb begin
        unique case (cond_i[CW-1:1])
            GRP_ZERO:  base = z;
            GRP_CARRY: base = c;
            GRP_NEG:   base = n;
            GRP_OVF:   base = v;
            GRP_HIGH:  base = c & ~z;
            GRP_SGE:   base = (n == v);
            GRP_SGT:   base = ~z & (n == v);
            GRP_ALW:   base = 1'b1;
            default:   base = 1'b1;
        endcase
    end

    // low code bit inverts, except in the always group
    assign holds_o = (cond_i[CW-1:1] == GRP_ALW) ? 1'b1 : (base ^ cond_i[0]);
endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
    import cbt_pkg::*;
#(
    parameter int MAX_SLOTS = 4,
    parameter int CW        = 4,
    localparam int CNT_W    = $clog2(MAX_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [CW-1:0]        cond_i,
    input  logic [CNT_W-1:0]     len_i,
    input  logic [MAX_SLOTS-2:0] else_i,
    input  logic                 adv_i,
    output logic                 active_o,
    output logic                 slot_else_o,
    output logic [CW-1:0]        cond_o,
    output logic [CNT_W-1:0]     remain_o
);
    cbt_state_e state_q, state_d;
    logic [CNT_W-1:0]     remain_q;
    logic [MAX_SLOTS-1:0] polar_q;
    logic [CW-1:0]        cond_q;
    logic                 load_ok;
    logic                 last_slot;

    assign load_ok   = load_i && (len_i != '0) && (len_i <= CNT_W'(MAX_SLOTS));
    assign last_slot = (remain_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_ok) state_d = ST_ACTIVE;                 // T_OPEN
            end
            ST_ACTIVE: begin
                if (load_ok)                state_d = ST_ACTIVE;  // T_RESTART
                else if (adv_i && last_slot) state_d = ST_IDLE;   // T_CLOSE
                else                        state_d = ST_ACTIVE;  // T_STEP / hold
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // slot bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            polar_q  <= '0;
            cond_q   <= '0;
        end else if (load_ok) begin
            remain_q <= len_i;
            polar_q  <= {else_i, 1'b0};
            cond_q   <= cond_i;
        end else if (state_q == ST_ACTIVE && adv_i) begin
            remain_q <= remain_q - CNT_W'(1);
            polar_q  <= polar_q >> 1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ACTIVE: begin
                active_o    = 1'b1;
                slot_else_o = polar_q[0];
            end
            default: begin
                active_o    = 1'b0;
                slot_else_o = 1'b0;
            end
        endcase
    end

    assign cond_o   = cond_q;
    assign remain_o = remain_q;
endmodule

// File: rtl/cond_block_tracker.sv
module cond_block_tracker #(
    parameter int MAX_SLOTS = 4,
    parameter int CW        = 4,
    localparam int CNT_W    = $clog2(MAX_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [CW-1:0]        cond_i,
    input  logic [CNT_W-1:0]     len_i,
    input  logic [MAX_SLOTS-2:0] else_i,
    input  logic                 adv_i,
    input  logic [3:0]           flags_i,
    output logic                 in_block_o,
    output logic                 exec_o,
    output logic [CNT_W-1:0]     remain_o
);
    logic          active;
    logic          slot_else;
    logic          holds;
    logic [CW-1:0] cur_cond;

    cbt_seq #(.MAX_SLOTS(MAX_SLOTS), .CW(CW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .cond_i      (cond_i),
        .len_i       (len_i),
        .else_i      (else_i),
        .adv_i       (adv_i),
        .active_o    (active),
        .slot_else_o (slot_else),
        .cond_o      (cur_cond),
        .remain_o    (remain_o)
    );

    cbt_cond_eval #(.CW(CW)) u_eval (
        .cond_i  (cur_cond),
        .flags_i (flags_i),
        .holds_o (holds)
    );

    assign in_block_o = active;
    assign exec_o     = ~active | (holds ^ slot_else);
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker #(
    parameter int MAX_SLOTS = 4,
    parameter int CW        = 4,
    localparam int CNT_W    = $clog2(MAX_SLOTS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load_i,
    input logic [CW-1:0]        cond_i,
    input logic [CNT_W-1:0]     len_i,
    input logic                 adv_i,
    input logic                 in_block_o,
    input logic                 exec_o,
    input logic [CNT_W-1:0]     remain_o
);
    logic len_ok;
    assign len_ok = (len_i != '0) && (len_i <= CNT_W'(MAX_SLOTS));

    a_r2_load_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && len_ok) |=> (in_block_o && remain_o == $past(len_i)));

    a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (in_block_o && adv_i && !load_i && remain_o > CNT_W'(1)) |=>
        (in_block_o && remain_o == $past(remain_o) - CNT_W'(1)));

    a_r6_close: assert property (@(posedge clk) disable iff (!rst_n)
        (in_block_o && adv_i && !load_i && remain_o == CNT_W'(1)) |=>
        (!in_block_o && remain_o == '0));

    a_r9_bad_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !len_ok && !adv_i) |=>
        ($stable(in_block_o) && $stable(remain_o)));

    a_r10_idle_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !in_block_o |-> (exec_o && remain_o == '0));

    a_r10_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_block_o && !load_i) |=> !in_block_o);

    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        in_block_o |-> (remain_o != '0 && remain_o <= CNT_W'(MAX_SLOTS)));
endmodule

bind cond_block_tracker cbt_checker #(.MAX_SLOTS(MAX_SLOTS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .cond_i     (cond_i),
    .len_i      (len_i),
    .adv_i      (adv_i),
    .in_block_o (in_block_o),
    .exec_o     (exec_o),
    .remain_o   (remain_o)
);

// File: tb/cond_block_tracker_test.sv
`timescale 1ns/1ps
module cond_block_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       load_i;
    logic [3:0] cond_i;
    logic [2:0] len_i;
    logic [2:0] else_i;
    logic       adv_i;
    logic [3:0] flags_i;
    logic       in_block_o;
    logic       exec_o;
    logic [2:0] remain_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cond_block_tracker uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .cond_i(cond_i),
        .len_i(len_i), .else_i(else_i), .adv_i(adv_i), .flags_i(flags_i),
        .in_block_o(in_block_o), .exec_o(exec_o), .remain_o(remain_o)
    );

    // {cond, flags NZCV, expected truth}
    localparam logic [8:0] VEC [14] = '{
        {4'b0000, 4'b0100, 1'b1},   // EQ, Z=1
        {4'b0001, 4'b0100, 1'b0},   // NE, Z=1
        {4'b1010, 4'b1001, 1'b1},   // GE, N=V=1
        {4'b1010, 4'b1000, 1'b0},   // GE, N!=V
        {4'b1011, 4'b1000, 1'b1},   // LT, N!=V
        {4'b1100, 4'b0000, 1'b1},   // GT
        {4'b1100, 4'b0100, 1'b0},   // GT with Z
        {4'b1101, 4'b0100, 1'b1},   // LE with Z
        {4'b1101, 4'b0001, 1'b1},   // LE, N!=V
        {4'b1000, 4'b0010, 1'b1},   // HI
        {4'b1001, 4'b0110, 1'b1},   // LS
        {4'b1110, 4'b0000, 1'b1},   // AL
        {4'b0100, 4'b1000, 1'b1},   // MI
        {4'b0111, 4'b0001, 1'b0}    // VC, V=1
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load_i = 0; cond_i = 0; len_i = 0; else_i = 0;
        adv_i = 0; flags_i = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 in_block", in_block_o, 0);
        chk("R1 remain", remain_o, 0);
        chk("R1 exec", exec_o, 1);

        // R5/R3: condition table, one-slot blocks
        for (int i = 0; i < 14; i++) begin
            load_i = 1; cond_i = VEC[i][8:5]; len_i = 3'd1; else_i = 3'b000;
            tick();
            load_i = 0; flags_i = VEC[i][4:1];
            #1;
            chk("R5 R3 exec", exec_o, int'(VEC[i][0]));
            chk("R2 remain", remain_o, 1);
            adv_i = 1;
            tick();
            adv_i = 0;
            chk("R6 closed", in_block_o, 0);
        end

        // R4/R7: then-then-else-else on LT, N=1 V=0
        flags_i = 4'b1000;
        load_i = 1; cond_i = 4'b1011; len_i = 3'd4; else_i = 3'b110;
        tick();
        load_i = 0;
        chk("R2 remain4", remain_o, 4);
        chk("R3 slot1", exec_o, 1);
        adv_i = 1;
        tick();
        chk("R6 remain3", remain_o, 3);
        chk("R4 slot2 then", exec_o, 1);
        tick();
        adv_i = 0;
        chk("R6 remain2", remain_o, 2);
        chk("R4 slot3 else", exec_o, 0);
        flags_i = 4'b0000;
        #1;
        chk("R7 live flags", exec_o, 1);
        adv_i = 1;
        tick();
        chk("R6 remain1", remain_o, 1);
        chk("R4 slot4 else", exec_o, 1);
        tick();
        adv_i = 0;
        chk("R6 exit", in_block_o, 0);
        chk("R6 remain0", remain_o, 0);

        // R8: restart mid-block
        flags_i = 4'b0000;
        load_i = 1; cond_i = 4'b0000; len_i = 3'd3; else_i = 3'b000;
        tick();
        load_i = 0; adv_i = 1;
        tick();
        adv_i = 0;
        chk("R6 before restart", remain_o, 2);
        load_i = 1; cond_i = 4'b0001; len_i = 3'd4;
        tick();
        load_i = 0;
        chk("R8 restart remain", remain_o, 4);
        chk("R8 restart cond", exec_o, 1);

        // R11: load and advance together
        load_i = 1; adv_i = 1; cond_i = 4'b0000; len_i = 3'd2; else_i = 3'b001;
        tick();
        load_i = 0; adv_i = 0;
        chk("R11 remain", remain_o, 2);
        chk("R11 cond", exec_o, 0);

        // R9: bad lengths while open
        load_i = 1; len_i = 3'd5; cond_i = 4'b1110;
        tick();
        load_i = 0;
        chk("R9 len5 remain", remain_o, 2);
        chk("R9 len5 exec", exec_o, 0);
        load_i = 1; len_i = 3'd0;
        tick();
        load_i = 0;
        chk("R9 len0 remain", remain_o, 2);
        adv_i = 1;
        tick();
        chk("R4 else slot2", exec_o, 1);
        tick();
        adv_i = 0;
        chk("R6 exit2", in_block_o, 0);

        // R9/R10 while idle
        load_i = 1; len_i = 3'd0;
        tick();
        load_i = 0;
        chk("R9 idle len0", in_block_o, 0);
        adv_i = 1; flags_i = 4'b0100;
        tick(); tick();
        adv_i = 0;
        chk("R10 idle remain", remain_o, 0);
        chk("R10 idle in_block", in_block_o, 0);
        chk("R10 idle exec", exec_o, 1);

        // R1: reset in the middle of a block
        load_i = 1; cond_i = 4'b0001; len_i = 3'd3;
        tick();
        load_i = 0; rst_n = 0;
        tick();
        rst_n = 1;
        chk("R1 reset clears", in_block_o, 0);
        chk("R1 reset remain", remain_o, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule